// File: doc/BRIEF.md
# I2C Read-Only Slave with Byte Status Codes

This block is an I2C target that serves read transfers aimed at its own 7-bit address. It resynchronises the bus lines, finds START and STOP conditions, collects the address byte and, when the direction bit asks for a read, sends bytes taken from a transmit data register while watching the acknowledge bit returned by the controller. At every byte boundary it raises an interrupt flag, posts an 8-bit status code, and holds SCL low until software has looked at the code, loaded the next byte and cleared the flag.

Software steers the transfer through three small registers reached by a one-cycle write strobe. An acknowledge-enable bit decides both whether the own address is answered and whether the byte being loaded is the final one. After a final byte, or a byte the controller refuses, the block lets go of the bus. It keeps watching for the next START, and the controller reads all ones in the meantime.

Top module: `i2c_txs_top`

## Requirements
- R1: An address byte whose upper seven bits equal the own address (register select 0, bits 7:1) with bit 0 = 1 (read) is acknowledged (SDA low during the ninth clock) when acknowledge-enable (register select 1, bit 0) is 1; the flag is then set and status A8h is posted.
- R2: Each data byte is the value of the transmit data register (register select 2) captured when the flag is cleared, sent MSB first; if acknowledge-enable was 1 at that moment and the controller acknowledges, status B8h is posted.
- R3: If the controller answers a data byte with NOT ACK, status C0h is posted and the block becomes not addressed.
- R4: If acknowledge-enable was 0 when the byte was loaded and the controller still acknowledges it, status C8h is posted and the block becomes not addressed.
- R5: While not addressed the block leaves SDA released, so further reads return FFh, and further clocks set no flag.
- R6: While acknowledge-enable is 0 the own address is not acknowledged and no flag is set; setting it to 1 restores recognition.
- R7: The all-zero address byte (general call) is acknowledged only when bit 0 of the address register is 1; it then posts 70h, and once the flag is cleared the block is not addressed and acknowledges no following byte.
- R8: After reset the flag is 0, neither line is driven, and the status output reads F8h whenever the flag is 0.
- R9: A STOP or repeated START seen while addressed sets the flag with status A0h, without holding SCL, and leaves the block not addressed; a STOP while not addressed sets no flag.
- R10: SCL is held low from a byte-boundary flag until software writes register select 1 with bit 1 = 0, which clears the flag and lets SCL go.
- R11: The own address with bit 0 = 0 (write) is not acknowledged and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_drive_low | output | 1 | 1 pulls SCL low (stretch) |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| reg_wr | input | 1 | One-cycle register write strobe |
| reg_sel | input | 2 | 0 address, 1 control, 2 transmit data |
| reg_wdata | input | 8 | Write data |
| irq_o | output | 1 | Interrupt flag |
| status_o | output | 8 | Posted status code, F8h when the flag is 0 |

## Verification
The flag release and the acknowledge-enable update land in the same clock, because both come from one control write, and the engine must take the last-byte decision from the value written in that very write. The bench provokes this by writing acknowledge-enable 0 together with the flag clear before the final byte. It judges the result by expecting C8h after the controller acknowledges, and B8h for every earlier byte where the same write carried acknowledge-enable 1.

// File: rtl/i2c_txs_pkg.sv
// Shared constants and types for the I2C read-only slave.
// Assumes 8-bit bytes and 7-bit addresses as fixed by the bus protocol.
package i2c_txs_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    // status codes posted at byte boundaries
    localparam logic [BYTE_W-1:0] ST_IDLE      = 8'hF8;
    localparam logic [BYTE_W-1:0] ST_ADDR_RD   = 8'hA8;
    localparam logic [BYTE_W-1:0] ST_DATA_ACK  = 8'hB8;
    localparam logic [BYTE_W-1:0] ST_DATA_NACK = 8'hC0;
    localparam logic [BYTE_W-1:0] ST_LAST_ACK  = 8'hC8;
    localparam logic [BYTE_W-1:0] ST_STOP      = 8'hA0;
    localparam logic [BYTE_W-1:0] ST_GCALL     = 8'h70;

    // register selects and control bit positions
    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_CTL  = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;
    localparam int CTL_AA_BIT   = 0;
    localparam int CTL_FLAG_BIT = 1;

    typedef enum logic [2:0] {
        EN_IDLE,
        EN_ADDR,
        EN_ADDR_ACK,
        EN_TX,
        EN_TX_ACK,
        EN_WAIT
    } eng_state_t;

endpackage

// File: rtl/i2c_txs_sync.sv
// Line conditioner: resynchronises SCL and SDA through STAGES flops
// (STAGES >= 2) and derives SCL edges plus START/STOP events.
// Assumes clk is several times faster than SCL.
module i2c_txs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o,
    output logic sda_o
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;
    logic              sda_s;

    // resynchronise both lines, idle-high after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_s;
            sda_d    <= sda_s;
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // edge and bus condition decode
    assign scl_rise_o = scl_s & ~scl_d;
    assign scl_fall_o = ~scl_s & scl_d;
    assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
    assign sda_o      = sda_s;

endmodule

// File: rtl/i2c_txs_regs.sv
// Software-facing registers: own address with general-call enable,
// control (acknowledge-enable, interrupt flag), transmit data, status.
// A posted event from the engine wins over a flag clear in the same cycle.
module i2c_txs_regs
    import i2c_txs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [1:0]        sel_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              post_i,
    input  logic [BYTE_W-1:0] post_code_i,
    output logic [ADDR_W-1:0] own_addr_o,
    output logic              gc_en_o,
    output logic              aa_o,
    output logic [BYTE_W-1:0] tx_data_o,
    output logic              flag_o,
    output logic [BYTE_W-1:0] status_o
);
    logic [ADDR_W-1:0] own_addr_q;
    logic              gc_en_q;
    logic              aa_q;
    logic [BYTE_W-1:0] tx_data_q;
    logic              flag_q;
    logic [BYTE_W-1:0] code_q;
    logic              clr_req;

    assign clr_req = wr_i && (sel_i == SEL_CTL) && !wdata_i[CTL_FLAG_BIT];

    // configuration and data register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_addr_q <= '0;
            gc_en_q    <= 1'b0;
            aa_q       <= 1'b0;
            tx_data_q  <= '0;
        end else if (wr_i) begin
            case (sel_i)
                SEL_ADDR: begin
                    own_addr_q <= wdata_i[BYTE_W-1:1];
                    gc_en_q    <= wdata_i[0];
                end
                SEL_CTL:  aa_q      <= wdata_i[CTL_AA_BIT];
                SEL_DATA: tx_data_q <= wdata_i;
                default:  ;
            endcase
        end
    end

    // interrupt flag and posted code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            code_q <= ST_IDLE;
        end else if (post_i) begin
            flag_q <= 1'b1;
            code_q <= post_code_i;
        end else if (clr_req) begin
            flag_q <= 1'b0;
        end
    end

    assign own_addr_o = own_addr_q;
    assign gc_en_o    = gc_en_q;
    assign aa_o       = aa_q;
    assign tx_data_o  = tx_data_q;
    assign flag_o     = flag_q;
    assign status_o   = flag_q ? code_q : ST_IDLE;

    // R10: the flag stays set until posted again or cleared by software
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q && !clr_req |=> flag_q);

endmodule

// File: rtl/i2c_txs_engine.sv
// Protocol engine of the read-only slave: collects the address byte,
// acknowledges a match, shifts data MSB first, samples the controller's
// acknowledge and posts a status code at each byte boundary, then holds
// SCL until the flag is cleared. Assumes conditioned edges from i2c_txs_sync.
module i2c_txs_engine
    import i2c_txs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              gc_en_i,
    input  logic              aa_i,
    input  logic [BYTE_W-1:0] tx_data_i,
    input  logic              flag_i,
    output logic              post_o,
    output logic [BYTE_W-1:0] post_code_o,
    output logic              sda_low_o,
    output logic              scl_hold_o
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    eng_state_t        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] shreg_q;
    logic              addressed_q;
    logic              is_gc_q;
    logic              last_q;
    logic              mack_q;
    logic              resume_q;
    logic              post_q;
    logic [BYTE_W-1:0] code_q;
    logic              own_hit;
    logic              gc_hit;

    // address decode of the collected byte
    assign own_hit = (shreg_q[BYTE_W-1:1] == own_addr_i) && shreg_q[0];
    assign gc_hit  = (shreg_q == '0) && gc_en_i;

    // bus protocol sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= EN_IDLE;
            cnt_q       <= '0;
            shreg_q     <= '0;
            addressed_q <= 1'b0;
            is_gc_q     <= 1'b0;
            last_q      <= 1'b0;
            mack_q      <= 1'b0;
            resume_q    <= 1'b0;
            post_q      <= 1'b0;
            code_q      <= ST_IDLE;
        end else begin
            post_q <= 1'b0;
            if (start_i) begin
                if (addressed_q) begin
                    post_q <= 1'b1;
                    code_q <= ST_STOP;
                end
                addressed_q <= 1'b0;
                cnt_q       <= '0;
                state_q     <= EN_ADDR;
            end else if (stop_i) begin
                if (addressed_q) begin
                    post_q <= 1'b1;
                    code_q <= ST_STOP;
                end
                addressed_q <= 1'b0;
                state_q     <= EN_IDLE;
            end else begin
                case (state_q)
                    EN_ADDR: begin
                        if (scl_rise_i && (cnt_q < CNT_FULL)) begin
                            shreg_q <= {shreg_q[BYTE_W-2:0], sda_i};
                            cnt_q   <= cnt_q + 1'b1;
                        end else if (scl_fall_i && (cnt_q == CNT_FULL)) begin
                            if (aa_i && (own_hit || gc_hit)) begin
                                is_gc_q <= gc_hit;
                                state_q <= EN_ADDR_ACK;
                            end else begin
                                state_q <= EN_IDLE;
                            end
                        end
                    end
                    EN_ADDR_ACK: begin
                        if (scl_fall_i) begin
                            post_q      <= 1'b1;
                            code_q      <= is_gc_q ? ST_GCALL : ST_ADDR_RD;
                            resume_q    <= !is_gc_q;
                            addressed_q <= 1'b1;
                            state_q     <= EN_WAIT;
                        end
                    end
                    EN_WAIT: begin
                        if (!post_q && !flag_i) begin
                            if (resume_q) begin
                                shreg_q <= tx_data_i;
                                last_q  <= !aa_i;
                                cnt_q   <= '0;
                                state_q <= EN_TX;
                            end else begin
                                addressed_q <= 1'b0;
                                state_q     <= EN_IDLE;
                            end
                        end
                    end
                    EN_TX: begin
                        if (scl_fall_i) begin
                            shreg_q <= {shreg_q[BYTE_W-2:0], 1'b1};
                            if (cnt_q == CNT_LAST) begin
                                state_q <= EN_TX_ACK;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                    EN_TX_ACK: begin
                        if (scl_rise_i) begin
                            mack_q <= !sda_i;
                        end else if (scl_fall_i) begin
                            post_q      <= 1'b1;
                            code_q      <= !mack_q ? ST_DATA_NACK :
                                           (last_q ? ST_LAST_ACK : ST_DATA_ACK);
                            resume_q    <= mack_q && !last_q;
                            addressed_q <= mack_q && !last_q;
                            state_q     <= EN_WAIT;
                        end
                    end
                    default: state_q <= EN_IDLE;
                endcase
            end
        end
    end

    assign post_o      = post_q;
    assign post_code_o = code_q;
    assign sda_low_o   = (state_q == EN_ADDR_ACK) ||
                         ((state_q == EN_TX) && !shreg_q[BYTE_W-1]);
    assign scl_hold_o  = (state_q == EN_WAIT);

    // R6: an address is only acknowledged if acknowledge-enable was set
    a_r6_ack_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EN_ADDR_ACK) && ($past(state_q) != EN_ADDR_ACK) |-> $past(aa_i));

    // R3: a refused byte leaves the block not addressed
    a_r3_nack_detaches: assert property (@(posedge clk) disable iff (!rst_n)
        post_q && (code_q == ST_DATA_NACK) |-> !addressed_q);

    // R5: outside the acknowledge slot a detached block never pulls SDA
    a_r5_detached_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !addressed_q && (state_q != EN_ADDR_ACK) |-> !sda_low_o);

    // R9: a START while addressed posts A0h on the next cycle
    a_r9_start_posts: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && addressed_q |=> post_q && (code_q == ST_STOP) && !addressed_q);

endmodule

// File: rtl/i2c_txs_top.sv
// Top of the I2C read-only slave with byte status codes. Ties the line
// conditioner, the protocol engine and the register block together.
// Assumes open-drain pads outside: a drive_low of 1 pulls the line low.
module i2c_txs_top
    import i2c_txs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic              irq_o,
    output logic [BYTE_W-1:0] status_o
);
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              sda_s;
    logic [ADDR_W-1:0] own_addr;
    logic              gc_en;
    logic              aa;
    logic [BYTE_W-1:0] tx_data;
    logic              flag;
    logic              post;
    logic [BYTE_W-1:0] post_code;

    i2c_txs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det),
        .sda_o      (sda_s)
    );

    i2c_txs_engine u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_rise_i  (scl_rise),
        .scl_fall_i  (scl_fall),
        .start_i     (start_det),
        .stop_i      (stop_det),
        .sda_i       (sda_s),
        .own_addr_i  (own_addr),
        .gc_en_i     (gc_en),
        .aa_i        (aa),
        .tx_data_i   (tx_data),
        .flag_i      (flag),
        .post_o      (post),
        .post_code_o (post_code),
        .sda_low_o   (sda_drive_low),
        .scl_hold_o  (scl_drive_low)
    );

    i2c_txs_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (reg_wr),
        .sel_i       (reg_sel),
        .wdata_i     (reg_wdata),
        .post_i      (post),
        .post_code_i (post_code),
        .own_addr_o  (own_addr),
        .gc_en_o     (gc_en),
        .aa_o        (aa),
        .tx_data_o   (tx_data),
        .flag_o      (flag),
        .status_o    (status_o)
    );

    assign irq_o = flag;

    // R10: a stretch is always accompanied by the flag one cycle later
    a_r10_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low) |=> irq_o);

    // R10: clearing the flag lets SCL go on the following cycle
    a_r10_release_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |=> !scl_drive_low);

endmodule

// File: tb/i2c_txs_top_tb.sv
// Bench: a bit-level bus controller model plus a software model that
// services the flag. A vector table drives one read transfer byte by byte,
// then directed tests cover reset, address filtering and bus conditions.
module i2c_txs_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int WD_CYCLES  = 150000;
    localparam logic [7:0] OWN_REG = 8'hB4;   // address 5Ah, general call off
    localparam logic [7:0] OWN_RD  = 8'hB5;
    localparam logic [7:0] OWN_WR  = 8'hB4;
    // fields: [17] ack-enable at load, [16] controller ACK, [15:8] data, [7:0] status
    localparam int NVEC = 4;
    localparam logic [17:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 8'hA5, 8'hB8},
        {1'b1, 1'b1, 8'h3C, 8'hB8},
        {1'b1, 1'b1, 8'h00, 8'hB8},
        {1'b0, 1'b1, 8'hC3, 8'hC8}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic       scl_drive_low;
    logic       sda_drive_low;
    logic       irq_o;
    logic [7:0] status_o;
    logic       scl_bus;
    logic       sda_bus;
    int         checks = 0;
    int         errors = 0;

    assign scl_bus = m_scl & ~scl_drive_low;
    assign sda_bus = m_sda & ~sda_drive_low;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_txs_top u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl_bus),
        .sda_i         (sda_bus),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low),
        .reg_wr        (reg_wr),
        .reg_sel       (reg_sel),
        .reg_wdata     (reg_wdata),
        .irq_o         (irq_o),
        .status_o      (status_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_scl_high();
        while (!scl_bus) tick(1);
    endtask

    task automatic m_start();
        m_sda = 1'b1; m_scl = 1'b1; wait_scl_high(); tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic m_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; wait_scl_high(); tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic m_wbit(input logic b);
        m_sda = b; tick(Q);
        m_scl = 1'b1; wait_scl_high(); tick(2*Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic m_rbit(output logic b);
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; wait_scl_high(); tick(Q);
        b = sda_bus; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic m_wbyte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) m_wbit(d[i]);
        m_rbit(b);
        ack = !b;
    endtask

    task automatic m_rbyte(input logic mack, output logic [7:0] d);
        logic b;
        d = 8'h00;
        for (int i = 0; i < 8; i++) begin
            m_rbit(b);
            d = {d[6:0], b};
        end
        m_wbit(!mack);
    endtask

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic       ack;
        logic [7:0] got;
        tick(4);
        rst_n = 1'b1;
        tick(4);
        // R8: reset state
        check8("R8 reset flag", {7'd0, irq_o}, 8'h00);
        check8("R8 reset status", status_o, 8'hF8);
        check8("R8 reset drives", {6'd0, scl_drive_low, sda_drive_low}, 8'h00);

        reg_write(2'd0, OWN_REG);
        // R6: acknowledge-enable 0 (reset value) ignores own address
        m_start(); m_wbyte(OWN_RD, ack); tick(2);
        check8("R6 no ack when disabled", {7'd0, ack}, 8'h00);
        check8("R6 no flag when disabled", {7'd0, irq_o}, 8'h00);
        m_stop();

        // R1/R6: enable and address for read
        reg_write(2'd1, 8'h01);
        m_start(); m_wbyte(OWN_RD, ack); tick(2);
        check8("R1 address ack", {7'd0, ack}, 8'h01);
        check8("R1 status A8", status_o, 8'hA8);
        check8("R10 SCL stretched", {7'd0, scl_drive_low}, 8'h01);

        // R2/R4: table walk, ack-enable written with the flag clear
        for (int v = 0; v < NVEC; v++) begin
            reg_write(2'd2, VEC[v][15:8]);
            reg_write(2'd1, {6'd0, 1'b0, VEC[v][17]});
            tick(3);
            check8("R10 SCL released", {7'd0, scl_drive_low}, 8'h00);
            m_rbyte(VEC[v][16], got); tick(2);
            check8("R2 byte on bus", got, VEC[v][15:8]);
            check8(VEC[v][17] ? "R2 status after ack" : "R4 status after last",
                   status_o, VEC[v][7:0]);
        end
        // R5: detached after C8
        reg_write(2'd1, 8'h01);
        m_rbyte(1'b1, got); tick(2);
        check8("R5 detached reads ones", got, 8'hFF);
        check8("R5 detached no flag", {7'd0, irq_o}, 8'h00);
        check8("R8 status idle", status_o, 8'hF8);
        m_stop(); tick(2);
        check8("R9 stop when detached", {7'd0, irq_o}, 8'h00);

        // R3: controller refuses a byte
        m_start(); m_wbyte(OWN_RD, ack); tick(2);
        check8("R3 address status", status_o, 8'hA8);
        reg_write(2'd2, 8'h81);
        reg_write(2'd1, 8'h01);
        m_rbyte(1'b0, got); tick(2);
        check8("R3 byte on bus", got, 8'h81);
        check8("R3 status C0", status_o, 8'hC0);
        reg_write(2'd1, 8'h01);
        m_rbyte(1'b1, got); tick(2);
        check8("R3 then detached", got, 8'hFF);
        check8("R3 no further flag", {7'd0, irq_o}, 8'h00);
        m_stop();

        // R9: STOP while addressed
        m_start(); m_wbyte(OWN_RD, ack); tick(2);
        reg_write(2'd2, 8'hFF);
        reg_write(2'd1, 8'h01);
        tick(4);
        m_stop(); tick(2);
        check8("R9 stop posts A0", status_o, 8'hA0);
        check8("R9 no stretch on A0", {7'd0, scl_drive_low}, 8'h00);
        reg_write(2'd1, 8'h01);

        // R9: repeated START while addressed, then R11 write direction
        m_start(); m_wbyte(OWN_RD, ack); tick(2);
        reg_write(2'd2, 8'hFF);
        reg_write(2'd1, 8'h01);
        tick(4);
        m_start(); tick(2);
        check8("R9 rep start posts A0", status_o, 8'hA0);
        reg_write(2'd1, 8'h01);
        m_wbyte(OWN_WR, ack); tick(2);
        check8("R11 write not acked", {7'd0, ack}, 8'h00);
        check8("R11 no flag", {7'd0, irq_o}, 8'h00);
        m_stop();

        // R1: foreign address ignored
        m_start(); m_wbyte(8'h67, ack); tick(2);
        check8("R1 foreign address", {7'd0, ack}, 8'h00);
        m_stop();

        // R7: general call gated by address bit 0
        m_start(); m_wbyte(8'h00, ack); tick(2);
        check8("R7 gc off no ack", {7'd0, ack}, 8'h00);
        m_stop();
        reg_write(2'd0, OWN_REG | 8'h01);
        m_start(); m_wbyte(8'h00, ack); tick(2);
        check8("R7 gc ack", {7'd0, ack}, 8'h01);
        check8("R7 gc status", status_o, 8'h70);
        reg_write(2'd1, 8'h01);
        m_wbyte(8'h55, ack); tick(2);
        check8("R7 gc data not acked", {7'd0, ack}, 8'h00);
        check8("R7 gc no flag", {7'd0, irq_o}, 8'h00);
        m_stop();

        tick(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule